// File: doc/BRIEF.md
# Scaled Index Shifter for Load/Store Addressing

This block produces the scaled index operand that an address adder combines with a base register during load and store address generation. It receives the raw index register value, a two-bit shift kind, a five-bit immediate amount and the current carry flag, and it returns the shifted or rotated index in the same cycle. It contains no storage: the output follows the inputs combinationally, so it can sit directly in front of the address adder inside one pipeline stage.

A zero immediate amount is not always a no-op. For the two right shifts it stands for a shift by the full word width, and for the rotate kind it selects a one-place rotate that feeds the carry flag into the top bit. The kind and amount are decoded once into an operation select, which then steers one of three barrel structures (left, right, rotate) onto the output.

The operand flows straight through within a cycle and carries no handshake; the consuming stage owns any valid/ready control, so back-pressure is applied upstream by holding the inputs stable.

Top module: `idx_scaled_shifter`

## Requirements
- R1: With shift_type = 2'b00, index_out equals index_in shifted left by shift_imm places (0 to 31), zeros entering at the bottom; shift_imm = 0 returns index_in unchanged.
- R2: With shift_type = 2'b01 and shift_imm nonzero, index_out equals index_in shifted right logically by shift_imm places, zeros entering at the top.
- R3: With shift_type = 2'b01 and shift_imm = 0, index_out is all zeros (a 32-place logical right shift).
- R4: With shift_type = 2'b10 and shift_imm nonzero, index_out equals index_in shifted right arithmetically by shift_imm places, copies of index_in[31] entering at the top.
- R5: With shift_type = 2'b10 and shift_imm = 0, index_out is all ones when index_in[31] is 1 and all zeros when it is 0.
- R6: With shift_type = 2'b11 and shift_imm nonzero, index_out equals index_in rotated right by shift_imm places.
- R7: With shift_type = 2'b11 and shift_imm = 0, index_out[31] equals carry_in and index_out[30:0] equals index_in[31:1].
- R8: carry_in has no effect on index_out except in the case of R7.
- R9: The block holds no state: index_out settles to the function of the present inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| index_in | input | 32 | Index register value to be scaled |
| shift_type | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate |
| shift_imm | input | 5 | Immediate shift amount; zero has special meaning for kinds 01, 10, 11 |
| carry_in | input | 1 | Current carry flag, used only by the one-place rotate through carry |
| index_out | output | 32 | Scaled index value |

## Verification
The embedded checks are immediate assertions evaluated whenever the inputs move, and they assume every input is a known 0 or 1; each check is skipped while any input is unknown, so nothing fires before the stimulus first drives the pins. The stimulus drives every input from time zero onward with fully known values, changes them only away from the sampling point, and sweeps all four kinds across all 32 amounts with the top index bit and the carry each both set and cleared, so the sign-fill, full-width and carry-insertion corners are all reached with legal values.

// File: rtl/idx_shift_pkg.sv
package idx_shift_pkg;

  // Shift kind field codes seen on the shift_type pin
  localparam logic [1:0] KIND_SHL  = 2'b00;
  localparam logic [1:0] KIND_SHRL = 2'b01;
  localparam logic [1:0] KIND_SHRA = 2'b10;
  localparam logic [1:0] KIND_ROT  = 2'b11;

  // Decoded operation steering the output mux
  typedef enum logic [2:0] {
    OP_SHL   = 3'd0,
    OP_SHRL  = 3'd1,
    OP_SHRA  = 3'd2,
    OP_ROT   = 3'd3,
    OP_ROTC  = 3'd4
  } shift_op_e;

endpackage

// File: rtl/idx_shift_decode.sv
module idx_shift_decode
  import idx_shift_pkg::*;
#(
  parameter int AMT_W = 5
) (
  input  logic [1:0]       kind,
  input  logic [AMT_W-1:0] amt,
  output shift_op_e        op,
  output logic             full_width
);

  logic amt_zero;
  assign amt_zero = (amt == '0);

  always_comb begin
    op         = OP_SHL;
    full_width = 1'b0;
    unique case (kind)
      KIND_SHL:  op = OP_SHL;
      KIND_SHRL: begin
        op         = OP_SHRL;
        full_width = amt_zero;
      end
      KIND_SHRA: begin
        op         = OP_SHRA;
        full_width = amt_zero;
      end
      default:   op = amt_zero ? OP_ROTC : OP_ROT;
    endcase
  end

  always_comb begin
    if (!$isunknown({kind, amt})) begin
      AST_FULL_ONLY_RIGHT: assert (!full_width || (kind == KIND_SHRL) || (kind == KIND_SHRA)); // R3
      AST_ROTC_ON_ZERO: assert ((op == OP_ROTC) == ((kind == KIND_ROT) && amt_zero)); // R7
    end
  end

endmodule

// File: rtl/idx_shift_left.sv
module idx_shift_left #(
  parameter int WIDTH = 32,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [WIDTH-1:0] data_o
);

  logic [WIDTH-1:0] stage [AMT_W+1];

  assign stage[0] = data_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_lvl
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt_i[k] ? {stage[k][WIDTH-STEP-1:0], {STEP{1'b0}}} : stage[k];
  end

  assign data_o = stage[AMT_W];

  always_comb begin
    if (!$isunknown({data_i, amt_i})) begin
      AST_SHL_ZERO_PASS: assert ((amt_i != '0) || (data_o == data_i)); // R1
      AST_SHL_LSB_CLEAR: assert ((amt_i == '0) || (data_o[0] == 1'b0)); // R1
    end
  end

endmodule

// File: rtl/idx_shift_right.sv
module idx_shift_right #(
  parameter int WIDTH = 32,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             arith_i,
  input  logic             full_i,
  output logic [WIDTH-1:0] data_o
);

  logic             fill;
  logic [WIDTH-1:0] stage [AMT_W+1];

  assign fill     = arith_i & data_i[WIDTH-1];
  assign stage[0] = data_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_lvl
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt_i[k] ? {{STEP{fill}}, stage[k][WIDTH-1:STEP]} : stage[k];
  end

  assign data_o = full_i ? {WIDTH{fill}} : stage[AMT_W];

  always_comb begin
    if (!$isunknown({data_i, amt_i, arith_i, full_i})) begin
      AST_SHRA_SIGN_KEEP: assert (!arith_i || (data_o[WIDTH-1] == data_i[WIDTH-1])); // R4
      AST_SHRL_TOP_CLEAR: assert (arith_i || ((amt_i == '0) && !full_i) || (data_o[WIDTH-1] == 1'b0)); // R2
    end
  end

endmodule

// File: rtl/idx_shift_rotate.sv
module idx_shift_rotate #(
  parameter int WIDTH = 32,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             thru_carry_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] data_o
);

  logic [WIDTH-1:0] stage [AMT_W+1];

  assign stage[0] = data_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_lvl
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt_i[k] ? {stage[k][STEP-1:0], stage[k][WIDTH-1:STEP]} : stage[k];
  end

  assign data_o = thru_carry_i ? {carry_i, data_i[WIDTH-1:1]} : stage[AMT_W];

  always_comb begin
    if (!$isunknown({data_i, amt_i, thru_carry_i, carry_i})) begin
      AST_ROT_KEEPS_ONES: assert (thru_carry_i || ($countones(data_o) == $countones(data_i))); // R6
    end
  end

endmodule

// File: rtl/idx_scaled_shifter.sv
module idx_scaled_shifter
  import idx_shift_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] index_in,
  input  logic [1:0]       shift_type,
  input  logic [AMT_W-1:0] shift_imm,
  input  logic             carry_in,
  output logic [WIDTH-1:0] index_out
);

  shift_op_e        op;
  logic             full_width;
  logic [WIDTH-1:0] shl_res;
  logic [WIDTH-1:0] shr_res;
  logic [WIDTH-1:0] rot_res;

  idx_shift_decode #(.AMT_W(AMT_W)) u_decode (
    .kind       (shift_type),
    .amt        (shift_imm),
    .op         (op),
    .full_width (full_width)
  );

  idx_shift_left #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_left (
    .data_i (index_in),
    .amt_i  (shift_imm),
    .data_o (shl_res)
  );

  idx_shift_right #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_right (
    .data_i  (index_in),
    .amt_i   (shift_imm),
    .arith_i (op == OP_SHRA),
    .full_i  (full_width),
    .data_o  (shr_res)
  );

  idx_shift_rotate #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_rotate (
    .data_i       (index_in),
    .amt_i        (shift_imm),
    .thru_carry_i (op == OP_ROTC),
    .carry_i      (carry_in),
    .data_o       (rot_res)
  );

  always_comb begin
    unique case (op)
      OP_SHL:           index_out = shl_res;
      OP_SHRL, OP_SHRA: index_out = shr_res;
      default:          index_out = rot_res;
    endcase
  end

  always_comb begin
    if (!$isunknown({index_in, shift_type, shift_imm, carry_in})) begin
      AST_SHRL_FULL_ZERO: assert (!((shift_type == 2'b01) && (shift_imm == '0)) || (index_out == '0)); // R3
      AST_SHRA_FULL_FILL: assert (!((shift_type == 2'b10) && (shift_imm == '0))
                                  || ($countones(index_out) == (index_in[WIDTH-1] ? WIDTH : 0))); // R5
      AST_ROTC_TOP_BIT: assert (!((shift_type == 2'b11) && (shift_imm == '0))
                                || ((index_out[WIDTH-1] == carry_in) && (index_out[WIDTH-2:0] == index_in[WIDTH-1:1]))); // R7
    end
  end

endmodule

// File: tb/tb_idx_scaled_shifter.sv
module tb_idx_scaled_shifter;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] index_in = '0;
  logic [1:0]  shift_type = '0;
  logic [4:0]  shift_imm = '0;
  logic        carry_in = 1'b0;
  logic [31:0] index_out;

  int tests = 0;
  int fails = 0;
  item_t sb_q[$];

  always #2 clk = ~clk; // 250 MHz

  idx_scaled_shifter dut (
    .index_in   (index_in),
    .shift_type (shift_type),
    .shift_imm  (shift_imm),
    .carry_in   (carry_in),
    .index_out  (index_out)
  );

  function automatic logic [31:0] model(input logic [31:0] v, input logic [1:0] t,
                                        input logic [4:0] a, input logic c);
    logic [63:0] dbl;
    int          n;
    n = int'(a);
    case (t)
      2'b00: return v << n;
      2'b01: return (n == 0) ? 32'h0 : (v >> n);
      2'b10: return (n == 0) ? {32{v[31]}} : 32'($signed(v) >>> n);
      default: begin
        if (n == 0) return {c, v[31:1]};
        dbl = {v, v} >> n;
        return dbl[31:0];
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] t, input logic [4:0] a);
    case (t)
      2'b00: return "R1";
      2'b01: return (a == 0) ? "R3" : "R2";
      2'b10: return (a == 0) ? "R5" : "R4";
      default: return (a == 0) ? "R7" : "R6";
    endcase
  endfunction

  task automatic push(input logic [31:0] v, input logic [1:0] t, input logic [4:0] a,
                      input logic c, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    index_in   = v;
    shift_type = t;
    shift_imm  = a;
    carry_in   = c;
    it.exp = model(v, t, a, c);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares at the falling edge, one cycle per pushed item
  always @(negedge clk) begin
    if (!rst && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      tests++;
      if (index_out !== it.exp) begin
        fails++;
        $display("FAIL %s: type=%b imm=%0d carry=%b in=%h got %h expected %h",
                 it.tag, shift_type, shift_imm, carry_in, index_in, index_out, it.exp);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : driver
    logic [31:0] base;
    logic [31:0] held;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Reset-time state: all-zero inputs give zero (R1)
    push(32'h0, 2'b00, 5'd0, 1'b0, "R1");

    // Directed corners
    push(32'h8000_0001, 2'b00, 5'd31, 1'b1, "R1");
    push(32'hFFFF_FFFF, 2'b01, 5'd0,  1'b1, "R3");
    push(32'h8000_0000, 2'b10, 5'd0,  1'b0, "R5");
    push(32'h7FFF_FFFF, 2'b10, 5'd0,  1'b1, "R5");
    push(32'h8000_0000, 2'b10, 5'd31, 1'b0, "R4");
    push(32'h8000_0000, 2'b01, 5'd31, 1'b0, "R2");
    push(32'h0000_0001, 2'b11, 5'd1,  1'b0, "R6");
    push(32'h0000_0001, 2'b11, 5'd0,  1'b1, "R7");
    push(32'hFFFF_FFFE, 2'b11, 5'd0,  1'b0, "R7");

    // Sweep: every kind, every amount, top bit and carry both ways
    for (int t = 0; t < 4; t++) begin
      for (int a = 0; a < 32; a++) begin
        for (int m = 0; m < 4; m++) begin
          base = $urandom();
          base[31] = m[0];
          push(base, 2'(t), 5'(a), m[1], tag_of(2'(t), 5'(a)));
        end
      end
    end

    // R8: carry flipped on non-carry cases, model ignores carry
    for (int t = 0; t < 4; t++) begin
      for (int a = 1; a < 32; a += 5) begin
        base = $urandom();
        push(base, 2'(t), 5'(a), 1'b0, "R8");
        push(base, 2'(t), 5'(a), 1'b1, "R8");
      end
    end
    push(32'hA5A5_5A5A, 2'b00, 5'd0, 1'b1, "R8");
    push(32'hA5A5_5A5A, 2'b01, 5'd0, 1'b1, "R8");
    push(32'hA5A5_5A5A, 2'b10, 5'd0, 1'b1, "R8");

    // R9: output follows an input change with no clock edge in between
    repeat (2) @(posedge clk);
    #1;
    index_in = 32'h1234_5678; shift_type = 2'b00; shift_imm = 5'd4; carry_in = 1'b0;
    #0.5;
    held = index_out;
    index_in = 32'h0000_00F0;
    #0.5;
    tests++;
    if (held !== 32'h2345_6780 || index_out !== 32'h0000_0F00) begin
      fails++;
      $display("FAIL R9: got %h/%h expected %h/%h", held, index_out, 32'h2345_6780, 32'h0000_0F00);
    end

    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule